// File: doc/BRIEF.md
# Multi-Mode Compare Timer

A 16-bit up-counter with two compare registers, a power-of-two prescaler and one setup register. Software reaches the block through four 16-bit registers that sit at byte offsets 0x0, 0x2, 0x4 and 0x6. Each of the two comparators has a mode: it can be off, fire when the count equals the compare value, fire on every count step at or above it, or fire on the equal value and then wrap the counter back to zero. This lets one timer serve as a periodic tick.

Comparator 2 can also raise a sticky reset request, which turns the timer into a watchdog. Software keeps the watchdog from firing by writing zero to the counter. The setup register takes a single configuration write after reset and ignores any later change, so code that goes wrong cannot disarm the watchdog. Each comparator has a sticky match flag in the setup register that is cleared by writing 1. Each interrupt pulse is masked by its own enable input, and the reset request has its own enable input.

Top module: `mmct_timer`

## Requirements
- R1: After reset every register reads 0, all outputs are low, and the counter stays at 0 while the enable bit (setup bit 15) is clear.
- R2: The registers are compare 1 at byte offset 0x0, compare 2 at 0x2, counter at 0x4 and setup at 0x6. A write to the counter loads the written value, so writing 0 restarts the count, and that write takes precedence over a count step in the same cycle. The compare registers read back what was written to them.
- R3: Setup bits [3:0] hold N, and the counter advances once per 2^N source clocks, counted from the setup write or from the last counter write.
- R4: When setup bit 4 is set, a source clock is a cycle with `alt_tick_i` high. When bit 4 is clear, every clock cycle is a source clock.
- R5: When setup bit 11 is set, the counter holds its value while `halt_i` is high. When bit 11 is clear, `halt_i` has no effect.
- R6: When setup bit 5 is set, the counter register reads back bit-reversed (bit 0 appears at bit 15).
- R7: Comparator modes are in setup [7:6] for comparator 1 and [9:8] for comparator 2. In mode 1 (equal), the hit is a one-cycle pulse in the cycle in which the counter first shows the compare value.
- R8: In mode 2 (greater-or-equal), a hit pulses on every count step whose new value is at least the compare value.
- R9: In mode 3 (event), a hit pulses when the counter reaches the compare value, and the next count step loads 0 instead of incrementing.
- R10: In mode 0 the comparator never hits and its flag stays clear.
- R11: A hit sets a sticky flag: setup bit 13 for comparator 1 and bit 14 for comparator 2. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R12: After the first write to setup, bits [11:0] and bit 15 keep their values until reset, and bit 12 reads 1.
- R13: `cmp1_irq_o` and `cmp2_irq_o` show the hit pulses only while `cmp1_irq_en_i` and `cmp2_irq_en_i` respectively are high. The flags are set whatever the state of these enables.
- R14: A comparator 2 hit while `wdog_rst_en_i` is high sets `rst_req_o`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| alt_tick_i | input | 1 | Alternate source clock enable |
| halt_i | input | 1 | Halt condition |
| cmp1_irq_en_i | input | 1 | Interrupt mask enable for comparator 1 |
| cmp2_irq_en_i | input | 1 | Interrupt mask enable for comparator 2 |
| wdog_rst_en_i | input | 1 | Reset-request enable for comparator 2 |
| cmp1_irq_o | output | 1 | Comparator 1 hit pulse |
| cmp2_irq_o | output | 1 | Comparator 2 hit pulse |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 4-bit divider field, which gives division ratios up to 2^15. Small compare values and a divider of 4 let every comparator mode, the wrap, the watchdog kick and expiry, and the exact prescaler step boundaries (39 against 40 clocks) be observed within a few dozen cycles per scenario. Counts near the 16-bit limit are not reached at these settings.

// File: rtl/mmct_pkg.sv
package mmct_pkg;
  typedef enum logic [1:0] {
    CMP_OFF = 2'd0,
    CMP_EQ  = 2'd1,
    CMP_GE  = 2'd2,
    CMP_EVT = 2'd3
  } cmp_mode_e;

  // setup[11:0]; msb first
  typedef struct packed {
    logic      stop_en;
    logic      rsvd;
    cmp_mode_e mode2;
    cmp_mode_e mode1;
    logic      rev;
    logic      src_sel;
    logic [3:0] div;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam logic [11:0] CFG_WMASK = 12'hBFF;
  localparam int LOCK_BIT = 12;
  localparam int FLAG_BIT = 13;
  localparam int EN_BIT = 15;

  localparam logic [1:0] RA_CMP1  = 2'd0;
  localparam logic [1:0] RA_CMP2  = 2'd1;
  localparam logic [1:0] RA_CNT   = 2'd2;
  localparam logic [1:0] RA_SETUP = 2'd3;
endpackage

// File: rtl/mmct_prescale.sv
module mmct_prescale #(
  parameter int DIV_W = 4,
  localparam int PS_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_en_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;

  assign mask   = ~({PS_W{1'b1}} << div_i);
  assign tick_o = src_en_i & run_i & ((ps_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ps_q <= '0;
    else if (clr_i)              ps_q <= '0;
    else if (src_en_i && run_i)  ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/mmct_cmp.sv
module mmct_cmp
  import mmct_pkg::*;
#(
  parameter int W = 16
) (
  input  cmp_mode_e      mode_i,
  input  logic [W-1:0]   cmp_i,
  input  logic [W-1:0]   cnt_nxt_i,
  input  logic           adv_i,
  output logic           hit_o
);
  always_comb begin
    unique case (mode_i)
      CMP_EQ, CMP_EVT: hit_o = adv_i & (cnt_nxt_i == cmp_i);
      CMP_GE:          hit_o = adv_i & (cnt_nxt_i >= cmp_i);
      default:         hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mmct_timer.sv
module mmct_timer
  import mmct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              alt_tick_i,
  input  logic              halt_i,
  input  logic              cmp1_irq_en_i,
  input  logic              cmp2_irq_en_i,
  input  logic              wdog_rst_en_i,
  output logic              cmp1_irq_o,
  output logic              cmp2_irq_o,
  output logic              rst_req_o
);
  localparam int NCMP = 2;

  logic [1:0]       reg_sel;
  logic             cnt_wr, setup_wr;
  cfg_t             cfg_q;
  logic             en_q, lock_q, rst_req_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_rev;
  logic [CNT_W-1:0] cmp_q [NCMP];
  logic             hit   [NCMP];
  logic             hit_q [NCMP];
  logic             flag_q[NCMP];
  logic             run, src_en, tick, adv, wrap;

  assign reg_sel  = addr_i[2:1];
  assign cnt_wr   = wr_en_i && (reg_sel == RA_CNT);
  assign setup_wr = wr_en_i && (reg_sel == RA_SETUP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (setup_wr && !lock_q) begin
      cfg_q  <= cfg_t'(wdata_i[CFG_W-1:0] & CFG_WMASK);
      en_q   <= wdata_i[EN_BIT];
      lock_q <= 1'b1;
    end
  end

  assign run    = en_q & ~(cfg_q.stop_en & halt_i);
  assign src_en = cfg_q.src_sel ? alt_tick_i : 1'b1;

  mmct_prescale #(.DIV_W(DIV_W)) u_ps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_en_i(src_en),
    .run_i   (run),
    .clr_i   (cnt_wr),
    .div_i   (cfg_q.div),
    .tick_o  (tick)
  );

  // event-mode wrap: step after reaching compare value loads zero
  assign wrap = ((cfg_q.mode1 == CMP_EVT) && (cnt_q == cmp_q[0])) ||
                ((cfg_q.mode2 == CMP_EVT) && (cnt_q == cmp_q[1]));
  assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
  assign adv     = tick & ~cnt_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wdata_i;
    else if (tick)    cnt_q <= cnt_nxt;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cmp_q[g] <= '0;
      else if (wr_en_i && (reg_sel == 2'(g)))       cmp_q[g] <= wdata_i;
    end

    mmct_cmp #(.W(CNT_W)) u_cmp (
      .mode_i   ((g == 0) ? cfg_q.mode1 : cfg_q.mode2),
      .cmp_i    (cmp_q[g]),
      .cnt_nxt_i(cnt_nxt),
      .adv_i    (adv),
      .hit_o    (hit[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q[g]  <= 1'b0;
        flag_q[g] <= 1'b0;
      end else begin
        hit_q[g]  <= hit[g];
        flag_q[g] <= (flag_q[g] & ~(setup_wr & wdata_i[FLAG_BIT+g])) | hit[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= rst_req_q | (hit[1] & wdog_rst_en_i);
  end

  for (genvar b = 0; b < CNT_W; b++) begin : g_rev
    assign cnt_rev[b] = cnt_q[CNT_W-1-b];
  end

  always_comb begin
    unique case (reg_sel)
      RA_CMP1: rdata_o = cmp_q[0];
      RA_CMP2: rdata_o = cmp_q[1];
      RA_CNT:  rdata_o = cfg_q.rev ? cnt_rev : cnt_q;
      default: rdata_o = CNT_W'({en_q, flag_q[1], flag_q[0], lock_q, cfg_q});
    endcase
  end

  assign cmp1_irq_o = hit_q[0] & cmp1_irq_en_i;
  assign cmp2_irq_o = hit_q[1] & cmp2_irq_en_i;
  assign rst_req_o  = rst_req_q;
endmodule

// File: rtl/mmct_timer_chk.sv
module mmct_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp1_irq_o,
  input logic             cmp2_irq_o,
  input logic             cmp1_irq_en_i,
  input logic             cmp2_irq_en_i,
  input logic             wdog_rst_en_i,
  input logic             rst_req_o,
  input logic             halt_i,
  input logic             lock,
  input logic             en,
  input logic [11:0]      cfg,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp1,
  input logic             tick,
  input logic             cnt_wr
);
  a_r14_rst_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  a_r14_rst_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(wdog_rst_en_i));

  a_r13_irq1_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp1_irq_en_i |-> !cmp1_irq_o);

  a_r13_irq2_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp2_irq_en_i |-> !cmp2_irq_o);

  a_r12_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> lock && $stable(cfg) && $stable(en));

  a_r5_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg[11] && halt_i && !cnt_wr) |=> $stable(cnt));

  a_r9_evt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg[7:6] == 2'd3 && tick && cnt == cmp1 && !cnt_wr) |=> cnt == '0);
endmodule

bind mmct_timer mmct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmp1_irq_o   (cmp1_irq_o),
  .cmp2_irq_o   (cmp2_irq_o),
  .cmp1_irq_en_i(cmp1_irq_en_i),
  .cmp2_irq_en_i(cmp2_irq_en_i),
  .wdog_rst_en_i(wdog_rst_en_i),
  .rst_req_o    (rst_req_o),
  .halt_i       (halt_i),
  .lock         (lock_q),
  .en           (en_q),
  .cfg          (cfg_q),
  .cnt          (cnt_q),
  .cmp1         (cmp_q[0]),
  .tick         (tick),
  .cnt_wr       (cnt_wr)
);

// File: tb/tb_mmct_timer.sv
module tb_mmct_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        alt_tick_i = 1'b0, halt_i = 1'b0;
  logic        cmp1_irq_en_i = 1'b0, cmp2_irq_en_i = 1'b0, wdog_rst_en_i = 1'b0;
  logic        cmp1_irq_o, cmp2_irq_o, rst_req_o;
  int          n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  mmct_timer dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic do_reset(input logic e1, input logic e2, input logic er);
    cmp1_irq_en_i = e1; cmp2_irq_en_i = e2; wdog_rst_en_i = er;
    halt_i = 1'b0; alt_tick_i = 1'b0; wr_en_i = 1'b0;
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    do_reset(1, 1, 1);
    rd(6, v); chk("R1 setup", v, 16'h0);
    rd(0, v); chk("R1 cmp1", v, 16'h0);
    step(5);
    rd(4, v); chk("R1 count idle", v, 16'h0);
    chk("R1 outputs", {13'd0, cmp1_irq_o, cmp2_irq_o, rst_req_o}, 16'h0);
  endtask

  task automatic t_equal_flags_lock;
    logic [15:0] v;
    int pulses = 0;
    do_reset(1, 1, 0);
    wr(0, 16'd5);
    rd(0, v); chk("R2 cmp1 readback", v, 16'd5);
    wr(6, 16'h8040);
    addr_i = 4;
    for (int i = 1; i <= 10; i++) begin
      step(1);
      #1;
      if (i == 3) chk("R2 count", rdata_o, 16'd3);
      if (cmp1_irq_o) pulses++;
      chk("R7 pulse at match", {15'd0, cmp1_irq_o}, {15'd0, (i == 5)});
    end
    chk("R7 single pulse", 16'(pulses), 16'd1);
    rd(6, v); chk("R11 flag set", v, 16'hB040);
    wr(6, 16'h0000);
    rd(6, v); chk("R12 locked, R11 write 0 keeps flag", v, 16'hB040);
    wr(6, 16'h2000);
    rd(6, v); chk("R11 write 1 clears", v, 16'h9040);
    wr(4, 16'd100);
    rd(4, v); chk("R2 counter load", v, 16'd100);
    step(2);
    rd(4, v); chk("R12 still counting", v, 16'd102);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    int seen = 0;
    do_reset(0, 0, 0);
    wr(0, 16'd2);
    wr(6, 16'h8040);
    for (int i = 0; i < 5; i++) begin
      step(1);
      if (cmp1_irq_o) seen++;
    end
    chk("R13 masked irq", 16'(seen), 16'd0);
    rd(6, v); chk("R13 flag still set", v & 16'h2000, 16'h2000);
  endtask

  task automatic t_ge;
    int pulses = 0;
    do_reset(1, 1, 0);
    wr(2, 16'd3);
    wr(6, 16'h8200);
    for (int i = 1; i <= 10; i++) begin
      step(1);
      if (cmp2_irq_o) pulses++;
      if (i == 2 || i == 3)
        chk("R8 ge edge", {15'd0, cmp2_irq_o}, {15'd0, (i >= 3)});
    end
    chk("R8 ge pulse count", 16'(pulses), 16'd8);
  endtask

  task automatic t_event;
    int pulses = 0;
    int bad = 0;
    do_reset(1, 1, 0);
    wr(0, 16'd4);
    wr(6, 16'h80C0);
    addr_i = 4;
    for (int i = 1; i <= 15; i++) begin
      step(1);
      #1;
      if (rdata_o !== 16'(i % 5)) bad++;
      if (cmp1_irq_o) pulses++;
    end
    chk("R9 wrap sequence mismatches", 16'(bad), 16'd0);
    chk("R9 event pulses", 16'(pulses), 16'd3);
  endtask

  task automatic t_off_and_halt_ignored;
    logic [15:0] v;
    int seen = 0;
    do_reset(1, 1, 0);
    wr(0, 16'd2);
    wr(6, 16'h8000);
    halt_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1);
      if (cmp1_irq_o) seen++;
    end
    rd(4, v); chk("R5 halt ignored without stop", v, 16'd4);
    chk("R10 off mode no irq", 16'(seen), 16'd0);
    rd(6, v); chk("R10 off mode no flag", v & 16'h6000, 16'h0);
    halt_i = 1'b0;
  endtask

  task automatic t_halt;
    logic [15:0] v;
    do_reset(1, 1, 0);
    wr(6, 16'h8800);
    step(3);
    halt_i = 1'b1;
    step(5);
    rd(4, v); chk("R5 frozen on halt", v, 16'd3);
    halt_i = 1'b0;
    step(2);
    rd(4, v); chk("R5 resumes", v, 16'd5);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    do_reset(1, 1, 0);
    wr(6, 16'h8002);
    step(39);
    rd(4, v); chk("R3 div4 after 40 clocks-1", v, 16'd9);
    step(1);
    rd(4, v); chk("R3 div4 after 40 clocks", v, 16'd10);
  endtask

  task automatic t_srcsel;
    logic [15:0] v;
    do_reset(1, 1, 0);
    wr(6, 16'h8010);
    step(5);
    rd(4, v); chk("R4 no alt ticks", v, 16'd0);
    for (int i = 0; i < 3; i++) begin
      alt_tick_i = 1'b1; step(1);
      alt_tick_i = 1'b0; step(2);
    end
    rd(4, v); chk("R4 alt ticks counted", v, 16'd3);
  endtask

  task automatic t_reverse;
    logic [15:0] v;
    do_reset(1, 1, 0);
    wr(6, 16'h8020);
    step(1);
    rd(4, v); chk("R6 reversed 1", v, 16'h8000);
    step(1);
    rd(4, v); chk("R6 reversed 2", v, 16'h4000);
  endtask

  task automatic t_watchdog;
    int early = 0;
    do_reset(1, 1, 1);
    wr(2, 16'd8);
    wr(6, 16'h8100);
    for (int k = 0; k < 6; k++) begin
      wr(4, 16'd0);
      for (int i = 0; i < 3; i++) begin
        step(1);
        if (rst_req_o) early++;
      end
    end
    chk("R14 kicked no reset", 16'(early), 16'd0);
    step(12);
    chk("R14 expiry reset", {15'd0, rst_req_o}, 16'd1);
    wr(4, 16'd0);
    step(2);
    chk("R14 reset sticky", {15'd0, rst_req_o}, 16'd1);
  endtask

  initial begin
    t_reset();
    t_equal_flags_lock();
    t_mask();
    t_ge();
    t_event();
    t_off_and_halt_ignored();
    t_halt();
    t_prescale();
    t_srcsel();
    t_reverse();
    t_watchdog();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule